// File: doc/BRIEF.md
# Cache-Aware DMA Read Command Selector

This block sits in front of a transmit DMA engine's bus master. Software or an upstream descriptor fetcher hands it one host buffer: a start byte address, a byte length and the cache line size in dwords. The block cuts the buffer into bursts of 4-byte beats at consecutive addresses. It tags every burst with the read command that matches its position relative to cache-line boundaries. An unaligned head that runs up to the next boundary is a line read. A run of whole lines is a multiple-line read. Anything that stays inside one line without reaching its end is a plain read.

Each burst is offered as a descriptor carrying start address, beat count, command and the number of valid bytes in its last beat. The descriptor is held under a valid/ready handshake. A transmit FIFO "almost full" flag is sampled when each burst is planned. While it is high, a multiple-line burst is cut to a single line, so the bus master can release the bus at a line boundary. The following burst picks up at the next line under the same rules. A one-cycle done pulse marks acceptance of the final burst.

Top module: `dma_rd_planner`

## Requirements
- R1: After reset, startReady is 1, burstValid is 0 and xferDone is 0.
- R2: When the current address is not line aligned and the remaining dwords reach the next line boundary, the burst command is line read (burstCmd = 2'b01) and its beat count ends the burst exactly on that boundary.
- R3: When the current address is line aligned, at least one whole line of dwords remains and almost-full was low at planning, the command is multiple-line read (burstCmd = 2'b10) covering every whole remaining line in one burst.
- R4: A burst that cannot reach a line boundary (an unaligned piece short of the boundary, or an aligned tail shorter than one line) is a plain read (burstCmd = 2'b00) covering all remaining dwords.
- R5: When fifoAlmostFull is high in the planning cycle of a multiple-line burst, that burst is exactly one line long, and the next burst starts at the following line and obeys R2 to R4 again.
- R6: The first burst starts at startAddr, each later burst starts 4 × beats bytes after the previous one, and the beat counts sum to ceil(startLen / 4); startAddr is expected to be dword aligned.
- R7: burstLastBytes is 4 on every burst except the final one, where it is startLen mod 4, or 4 when that is 0.
- R8: If lineDw is neither 8 nor 16 at start, the whole buffer is issued as one plain-read burst.
- R9: xferDone is high for exactly the one cycle that follows the handshake of the final burst, and startReady is high again in that cycle.
- R10: While burstValid is high and burstReady is low, every burst field stays unchanged, even if fifoAlmostFull changes.
- R11: While a buffer is in progress, startReady is low and startValid has no effect on the burst stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | New buffer request |
| startReady | output | 1 | Block idle, request accepted when startValid is high |
| startAddr | input | ADDR_W (32) | Buffer start byte address, dword aligned |
| startLen | input | LEN_W (12) | Buffer length in bytes, at least 4 |
| lineDw | input | LINE_W (5) | Cache line size in dwords (8 or 16 enable line commands) |
| fifoAlmostFull | input | 1 | Transmit FIFO headroom low, sampled when a burst is planned |
| burstValid | output | 1 | Burst descriptor offered |
| burstReady | input | 1 | Bus master takes the descriptor |
| burstAddr | output | ADDR_W (32) | Burst start byte address |
| burstBeats | output | LEN_W-1 (11) | Number of dword beats in the burst |
| burstCmd | output | 2 | 00 plain read, 01 line read, 10 multiple-line read |
| burstLastBytes | output | 3 | Valid bytes in the burst's last beat, 1 to 4 |
| xferDone | output | 1 | One-cycle pulse after the final burst is taken |

## Verification
The hard case to reach is a buffer whose plan changes between bursts. This happens when the almost-full flag toggles between planning cycles, so a multiple-line run is broken into single lines and then resumes with a long burst. It must do so without losing or repeating a dword. The bench sweeps every dword start offset within a line for both legal line sizes, over a dense spread of lengths with all four residues mod 4. It repeats the sweep with almost-full held low, held high, and flipped on alternate bursts. It drives the flag in the exact cycle each burst is planned, and flips it again while a descriptor is being held.

// File: rtl/rdplan_pkg.sv
package rdplan_pkg;

  typedef enum logic [1:0] {
    CMD_MR  = 2'b00,
    CMD_MRL = 2'b01,
    CMD_MRM = 2'b10
  } rdCmdE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAN,
    ST_OFFER
  } planStateE;

  typedef struct packed {
    logic load;
    logic capture;
    logic advance;
  } ctlStrobeT;

endpackage

// File: rtl/rdplan_datapath.sv
module rdplan_datapath
  import rdplan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int LINE_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobeT           strobe,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [LEN_W-1:0]    startLen,
  input  logic [LINE_W-1:0]   lineDw,
  input  logic                fifoAlmostFull,
  output logic [ADDR_W-1:0]   burstAddr,
  output logic [LEN_W-2:0]    burstBeats,
  output logic [1:0]          burstCmd,
  output logic [2:0]          burstLastBytes,
  output logic                finalQ
);

  localparam int BEAT_W = LEN_W - 1;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remBytes;
  logic [LINE_W-1:0] lineQ;

  logic [BEAT_W-1:0] beatsQ;
  rdCmdE             cmdQ;
  logic [2:0]        lastQ;

  logic [BEAT_W-1:0] remDw;
  logic [LINE_W-1:0] lineMask;
  logic [LINE_W-1:0] offDw;
  logic [BEAT_W-1:0] toBoundary;
  logic [BEAT_W-1:0] wholeDw;
  logic              lineOk;
  logic [BEAT_W-1:0] nextBeats;
  rdCmdE             nextCmd;
  logic              nextFinal;
  logic [2:0]        nextLast;

  always_comb begin
    remDw      = BEAT_W'((32'(remBytes) + 32'd3) >> 2);
    lineMask   = lineQ - LINE_W'(1);
    offDw      = curAddr[2 +: LINE_W] & lineMask;
    toBoundary = BEAT_W'(lineQ) - BEAT_W'(offDw);
    wholeDw    = remDw & ~BEAT_W'(lineMask);
    lineOk     = (lineQ == LINE_W'(8)) || (lineQ == LINE_W'(16));

    if (!lineOk) begin
      nextCmd   = CMD_MR;
      nextBeats = remDw;
    end else if (offDw != '0) begin
      if (remDw >= toBoundary) begin
        nextCmd   = CMD_MRL;
        nextBeats = toBoundary;
      end else begin
        nextCmd   = CMD_MR;
        nextBeats = remDw;
      end
    end else if (wholeDw != '0) begin
      nextCmd   = CMD_MRM;
      nextBeats = fifoAlmostFull ? BEAT_W'(lineQ) : wholeDw;
    end else begin
      nextCmd   = CMD_MR;
      nextBeats = remDw;
    end

    nextFinal = (nextBeats == remDw);
    if (nextFinal && (remBytes[1:0] != 2'b00)) begin
      nextLast = {1'b0, remBytes[1:0]};
    end else begin
      nextLast = 3'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBytes <= '0;
      lineQ    <= '0;
      beatsQ   <= '0;
      cmdQ     <= CMD_MR;
      lastQ    <= 3'd4;
      finalQ   <= 1'b0;
    end else begin
      if (strobe.load) begin
        curAddr  <= startAddr;
        remBytes <= startLen;
        lineQ    <= lineDw;
      end else if (strobe.advance) begin
        curAddr  <= curAddr + ADDR_W'({beatsQ, 2'b00});
        remBytes <= finalQ ? '0 : (remBytes - LEN_W'({beatsQ, 2'b00}));
      end
      if (strobe.capture) begin
        beatsQ <= nextBeats;
        cmdQ   <= nextCmd;
        lastQ  <= nextLast;
        finalQ <= nextFinal;
      end
    end
  end

  assign burstAddr      = curAddr;
  assign burstBeats     = beatsQ;
  assign burstCmd       = cmdQ;
  assign burstLastBytes = lastQ;

endmodule

// File: rtl/rdplan_ctrl.sv
module rdplan_ctrl
  import rdplan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      burstReady,
  input  logic      finalQ,
  output logic      startReady,
  output logic      burstValid,
  output logic      xferDone,
  output ctlStrobeT strobe
);

  planStateE state;

  always_comb begin
    strobe.load    = (state == ST_IDLE) && startValid;
    strobe.capture = (state == ST_PLAN);
    strobe.advance = (state == ST_OFFER) && burstReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      xferDone <= 1'b0;
    end else begin
      xferDone <= strobe.advance && finalQ;
      case (state)
        ST_IDLE:  if (strobe.load) state <= ST_PLAN;
        ST_PLAN:  state <= ST_OFFER;
        ST_OFFER: if (strobe.advance) state <= finalQ ? ST_IDLE : ST_PLAN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign startReady = (state == ST_IDLE);
  assign burstValid = (state == ST_OFFER);

endmodule

// File: rtl/dma_rd_planner.sv
module dma_rd_planner
  import rdplan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  startLen,
  input  logic [LINE_W-1:0] lineDw,
  input  logic              fifoAlmostFull,
  output logic              burstValid,
  input  logic              burstReady,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-2:0]  burstBeats,
  output logic [1:0]        burstCmd,
  output logic [2:0]        burstLastBytes,
  output logic              xferDone
);

  ctlStrobeT strobe;
  logic      finalQ;

  rdplan_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .burstReady (burstReady),
    .finalQ     (finalQ),
    .startReady (startReady),
    .burstValid (burstValid),
    .xferDone   (xferDone),
    .strobe     (strobe)
  );

  rdplan_datapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .LINE_W (LINE_W)
  ) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .startAddr      (startAddr),
    .startLen       (startLen),
    .lineDw         (lineDw),
    .fifoAlmostFull (fifoAlmostFull),
    .burstAddr      (burstAddr),
    .burstBeats     (burstBeats),
    .burstCmd       (burstCmd),
    .burstLastBytes (burstLastBytes),
    .finalQ         (finalQ)
  );

endmodule

// File: rtl/rdplan_chk.sv
module rdplan_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int LINE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              startReady,
  input logic [ADDR_W-1:0] startAddr,
  input logic [LEN_W-1:0]  startLen,
  input logic [LINE_W-1:0] lineDw,
  input logic              fifoAlmostFull,
  input logic              burstValid,
  input logic              burstReady,
  input logic [ADDR_W-1:0] burstAddr,
  input logic [LEN_W-2:0]  burstBeats,
  input logic [1:0]        burstCmd,
  input logic [2:0]        burstLastBytes,
  input logic              xferDone
);

  localparam int BEAT_W = LEN_W - 1;

  logic [LINE_W-1:0] cfgLine;
  logic [ADDR_W-1:0] expAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLine <= '0;
      expAddr <= '0;
    end else if (startValid && startReady) begin
      cfgLine <= lineDw;
      expAddr <= startAddr;
    end else if (burstValid && burstReady) begin
      expAddr <= burstAddr + ADDR_W'({burstBeats, 2'b00});
    end
  end

  // R2
  mrl_ends_on_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && burstCmd == 2'b01) |->
      (((burstAddr[2 +: LINE_W] + LINE_W'(burstBeats)) & (cfgLine - LINE_W'(1))) == '0));

  // R3
  mrm_whole_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && burstCmd == 2'b10) |->
      ((burstAddr[2 +: LINE_W] & (cfgLine - LINE_W'(1))) == '0) &&
      ((burstBeats & BEAT_W'(cfgLine - LINE_W'(1))) == '0) && (burstBeats != '0));

  // R5
  af_one_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(burstValid) && $past(fifoAlmostFull) && burstCmd == 2'b10) |->
      (burstBeats == BEAT_W'(cfgLine)));

  // R6
  contiguous_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> (burstAddr == expAddr));

  // R7
  partial_only_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && burstReady && burstLastBytes != 3'd4) |=> xferDone);

  // R9
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> $past(burstValid && burstReady));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstValid && !burstReady) |=>
      (burstValid && $stable(burstAddr) && $stable(burstBeats) &&
       $stable(burstCmd) && $stable(burstLastBytes)));

  // R11
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(startReady && burstValid));

endmodule

bind dma_rd_planner rdplan_chk #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .LINE_W (LINE_W)
) i_chk (.*);

// File: tb/test_dma_rd_planner.sv
module test_dma_rd_planner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [31:0] startAddr = '0;
  logic [11:0] startLen = '0;
  logic [4:0]  lineDw = '0;
  logic        fifoAlmostFull = 1'b0;
  logic        burstValid;
  logic        burstReady = 1'b0;
  logic [31:0] burstAddr;
  logic [10:0] burstBeats;
  logic [1:0]  burstCmd;
  logic [2:0]  burstLastBytes;
  logic        xferDone;

  int nVec = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  dma_rd_planner i_dma_rd_planner (
    .clk            (clk),
    .rstN           (rstN),
    .startValid     (startValid),
    .startReady     (startReady),
    .startAddr      (startAddr),
    .startLen       (startLen),
    .lineDw         (lineDw),
    .fifoAlmostFull (fifoAlmostFull),
    .burstValid     (burstValid),
    .burstReady     (burstReady),
    .burstAddr      (burstAddr),
    .burstBeats     (burstBeats),
    .burstCmd       (burstCmd),
    .burstLastBytes (burstLastBytes),
    .xferDone       (xferDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit afFor(input int mode, input int idx);
    return (mode == 1) || (mode == 2 && (idx % 2) == 0);
  endfunction

  task automatic runBuffer(input int a, input int len, input int line, input int mode);
    int curA = a;
    int rem = len;
    int idx = 0;
    int sumBeats = 0;
    bit done = 0;
    @(negedge clk);
    startAddr = 32'(a);
    startLen = 12'(len);
    lineDw = 5'(line);
    fifoAlmostFull = afFor(mode, 0);
    startValid = 1'b1;
    check(startReady == 1'b1, "R9", int'(startReady), 1);
    @(posedge clk);
    @(negedge clk);
    startValid = 1'b0;
    while (!done) begin
      int remDw, off, expBeats, expCmd, expLast;
      bit fin, af;
      string cmdTag;
      logic [31:0] hAddr;
      logic [10:0] hBeats;
      logic [1:0]  hCmd;
      logic [2:0]  hLast;
      while (!burstValid) @(negedge clk);
      af = afFor(mode, idx);
      remDw = (rem + 3) / 4;
      off = (curA / 4) % ((line == 0) ? 1 : line);
      if (line != 8 && line != 16) begin
        expCmd = 0; expBeats = remDw; cmdTag = "R8";
      end else if (off != 0) begin
        if (remDw >= line - off) begin
          expCmd = 1; expBeats = line - off; cmdTag = "R2";
        end else begin
          expCmd = 0; expBeats = remDw; cmdTag = "R4";
        end
      end else if (remDw >= line) begin
        expCmd = 2;
        expBeats = af ? line : (remDw / line) * line;
        cmdTag = af ? "R5" : "R3";
      end else begin
        expCmd = 0; expBeats = remDw; cmdTag = "R4";
      end
      fin = (expBeats == remDw);
      expLast = (fin && (rem % 4) != 0) ? rem % 4 : 4;
      check(int'(burstCmd) == expCmd, cmdTag, int'(burstCmd), expCmd);
      check(int'(burstBeats) == expBeats, cmdTag, int'(burstBeats), expBeats);
      check(burstAddr == 32'(curA), "R6", int'(burstAddr), curA);
      check(int'(burstLastBytes) == expLast, "R7", int'(burstLastBytes), expLast);
      check(xferDone == 1'b0, "R9", int'(xferDone), 0);
      check(startReady == 1'b0, "R11", int'(startReady), 0);
      hAddr = burstAddr; hBeats = burstBeats; hCmd = burstCmd; hLast = burstLastBytes;
      fifoAlmostFull = ~fifoAlmostFull;
      startValid = 1'b1;
      startAddr = 32'h00FF_FF00;
      startLen = 12'd9;
      @(negedge clk);
      startValid = 1'b0;
      check(burstValid && burstAddr == hAddr && burstBeats == hBeats &&
            burstCmd == hCmd && burstLastBytes == hLast, "R10",
            int'(burstBeats), int'(hBeats));
      burstReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      burstReady = 1'b0;
      sumBeats += expBeats;
      curA += 4 * expBeats;
      rem = fin ? 0 : rem - 4 * expBeats;
      idx++;
      if (fin) begin
        check(xferDone == 1'b1, "R9", int'(xferDone), 1);
        check(startReady == 1'b1, "R9", int'(startReady), 1);
        check(sumBeats == (len + 3) / 4, "R6", sumBeats, (len + 3) / 4);
        @(negedge clk);
        check(xferDone == 1'b0, "R9", int'(xferDone), 0);
        done = 1;
      end else begin
        fifoAlmostFull = afFor(mode, idx);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(startReady == 1'b1, "R1", int'(startReady), 1);
    check(burstValid == 1'b0, "R1", int'(burstValid), 0);
    check(xferDone == 1'b0, "R1", int'(xferDone), 0);

    // worked case: 1514 bytes starting 4 bytes past a 64-byte line
    runBuffer(64 * 3 + 4, 1514, 16, 0);
    runBuffer(64 * 3 + 4, 1514, 16, 1);

    for (int mode = 0; mode < 3; mode++) begin
      for (int sel = 0; sel < 2; sel++) begin
        int line = (sel == 0) ? 8 : 16;
        for (int off = 0; off < line; off++) begin
          for (int len = 4; len <= 200; len += 3) begin
            runBuffer(32'h1000 + off * 4, len, line, mode);
          end
        end
      end
    end

    // R8 unsupported line sizes
    for (int k = 0; k < 4; k++) begin
      int bad = (k == 0) ? 4 : (k == 1) ? 12 : (k == 2) ? 0 : 24;
      runBuffer(32'h2004, 150 + k, bad, k % 3);
      runBuffer(32'h2040, 4 + k, bad, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule